// File: doc/BRIEF.md
# Translation Table Update Engine

This block maintains a table of address translation entries on behalf of software. One command at a time arrives on a command channel. Each command carries an opcode, a table identifier, an I/O bus address, an argument and a page count. The engine checks the arguments and then steps through the pages the command covers. Every command ends with a status code on a response channel.

Four opcodes exist:

- A single-page write.
- A single-page read.
- A fill, which writes one value to a run of consecutive pages.
- A list write, which fetches per-page entries from system memory through a simple read port.

Each entry that is written also raises a one-cycle notification. It carries the new mapping, so that downstream translation caches can drop or refresh their copy.

The table sits inside the block as a register array that reset clears. Its size, page size, bus window offset and table identifier are parameters. With the defaults the table has 64 entries of 4 KiB pages. The window starts at bus address 0x10_0000, and the identifier is 0x8000_0001.

Top module: `xlt_update_engine`

## Requirements
- R1: The command address is first rounded down to a page boundary. The table index is (rounded address − BUS_OFFSET) >> PAGE_SHIFT. A write stores cmd_arg at that index.
- R2: An index at or above ENTRIES returns status 1 (parameter error) and leaves the table unchanged. This includes an address below BUS_OFFSET, whose difference wraps to a huge value. A command that passes every check returns status 0 (success).
- R3: A command whose cmd_id has any of bits 63:32 set, or whose bits 31:0 differ from TABLE_ID, returns status 1 and writes nothing.
- R4: A read (cmd_op 1) returns the raw 64-bit entry on rsp_data with status 0. Whenever the status is not 0, rsp_data is zero.
- R5: A fill (cmd_op 2) writes cmd_arg to cmd_count consecutive pages, starting at the addressed page. A count of 0, or a count above ENTRIES, returns status 1 and writes nothing.
- R6: A list write (cmd_op 3) returns status 1 without touching memory in three cases: the count is 0, the count is above 512, or cmd_arg (the list address) has any of bits 11:0 set. A count of exactly 512 is accepted.
- R7: The list write reads entry i from address cmd_arg + 8·i. The byte on mem_rdata[7:0] is the byte at the lowest address, and it is the most significant byte of the entry (big-endian).
- R8: A multi-page command moves forward one page per step. It stops at the first page whose index fails and returns status 1. Pages before that page keep their new values; later pages are not touched.
- R9: Every entry written raises ntf_valid for one cycle, with four fields:
  - ntf_iova = (page address − BUS_OFFSET) rounded to the page.
  - ntf_xlate = entry with the in-page bits cleared.
  - ntf_mask = 2^PAGE_SHIFT − 1.
  - ntf_perm = entry[1:0], where bit 0 grants read and bit 1 grants write.
- R10: cmd_op 0 is the single write. cmd_ready stays low from the moment a command is accepted until its response is taken (rsp_valid and rsp_ready both high). rsp_status and rsp_data hold steady while rsp_valid waits.
- R11: After reset every table entry reads 0, cmd_ready is high, and rsp_valid, ntf_valid and mem_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle and takes a command |
| cmd_op | input | 2 | 0 write, 1 read, 2 fill, 3 list write |
| cmd_id | input | 64 | Table identifier |
| cmd_addr | input | 64 | I/O bus address |
| cmd_arg | input | 64 | Entry value (write, fill) or list address (list write) |
| cmd_count | input | 32 | Page count for fill and list write |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_status | output | 2 | 0 success, 1 parameter error |
| rsp_data | output | 64 | Entry returned by a read |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 64 | Address of the list entry being read |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data, lowest-address byte in bits 7:0 |
| ntf_valid | output | 1 | Entry written this cycle |
| ntf_iova | output | 64 | Page-aligned offset address of the written page |
| ntf_xlate | output | 64 | Translated page address |
| ntf_mask | output | 64 | In-page offset mask |
| ntf_perm | output | 2 | Access rights: bit 0 read, bit 1 write |

## Verification
Single writes and reads run at several addresses:

- An in-page offset, which shows whether the rounding step happens.
- The first and the last table slot, and one slot past the end. These find an off-by-one in the bound.
- An address just below the window, which catches a signed or non-wrapping index.
- Two kinds of bad identifier: one with upper bits set and one that mismatches the low word. These show whether both halves are compared.

Fills and list writes run with three kinds of count:

- A legal count, then reads back across the run and its neighbour.
- A count at the limit and a count one past it.
- A count that runs off the end of the table.

These separate the up-front checks from the per-page abort, and show that the pages already done survive. A list of asymmetric byte patterns catches a byte order that is reversed. Counting the notifications and memory reads shows that rejected commands have no side effects.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

  typedef enum logic [1:0] {
    OP_PUT  = 2'd0,
    OP_GET  = 2'd1,
    OP_FILL = 2'd2,
    OP_LIST = 2'd3
  } op_e;

  localparam logic [1:0] STS_OK   = 2'd0;
  localparam logic [1:0] STS_PARM = 2'd1;

  // Mask that keeps the page number and clears the in-page offset
  function automatic logic [63:0] pg_mask(input int unsigned sh);
    return ~((64'd1 << sh) - 64'd1);
  endfunction

  // Table slot for a page address inside the bus window
  function automatic logic [63:0] tbl_index(input logic [63:0] addr,
                                            input logic [63:0] base,
                                            input int unsigned sh);
    return (addr - base) >> sh;
  endfunction

  // Access rights: bit 0 read, bit 1 write
  function automatic logic [1:0] perm_of(input logic [63:0] entry);
    return {entry[1], entry[0]};
  endfunction

  // Lowest-address byte arrives in bits 7:0 and is the most significant
  function automatic logic [63:0] be_swap(input logic [63:0] raw);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) begin
      r[8*(7-b) +: 8] = raw[8*b +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/xlt_table.sv
module xlt_table #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [63:0]      wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [63:0]      rdata
);

  logic [63:0] ent [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent[g] <= '0;
      end else if (we && waddr == IDX_W'(g)) begin
        ent[g] <= wdata;
      end
    end
  end

  assign rdata = ent[raddr];

endmodule

// File: rtl/xlt_fetch.sv
module xlt_fetch
  import xlt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] addr,
  output logic        mem_req,
  output logic [63:0] mem_addr,
  input  logic        mem_ack,
  input  logic [63:0] mem_rdata,
  output logic        done,
  output logic [63:0] value
);

  logic        busy_q;
  logic [63:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      done   <= 1'b0;
      value  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy_q && start) begin
        busy_q <= 1'b1;
        addr_q <= addr;
      end else if (busy_q && mem_ack) begin
        busy_q <= 1'b0;
        done   <= 1'b1;
        value  <= be_swap(mem_rdata);
      end
    end
  end

  assign mem_req  = busy_q;
  assign mem_addr = addr_q;

endmodule

// File: rtl/xlt_seq.sv
module xlt_seq
  import xlt_pkg::*;
#(
  parameter int          ENTRIES    = 64,
  parameter int          PAGE_SHIFT = 12,
  parameter logic [63:0] BUS_OFFSET = 64'h0010_0000,
  parameter logic [31:0] TABLE_ID   = 32'h8000_0001,
  parameter int          MAX_LIST   = 512,
  parameter int          LIST_ALIGN = 12,
  parameter int          CNT_W      = 32,
  parameter int          IDX_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  op_e              cmd_op,
  input  logic [63:0]      cmd_id,
  input  logic [63:0]      cmd_addr,
  input  logic [63:0]      cmd_arg,
  input  logic [CNT_W-1:0] cmd_count,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [1:0]       rsp_status,
  output logic [63:0]      rsp_data,
  output logic             fetch_start,
  output logic [63:0]      fetch_addr,
  input  logic             fetch_done,
  input  logic [63:0]      fetch_value,
  output logic             tbl_we,
  output logic [IDX_W-1:0] tbl_idx,
  output logic [63:0]      tbl_wdata,
  input  logic [63:0]      tbl_rdata,
  output logic             ntf_valid,
  output logic [63:0]      ntf_iova,
  output logic [63:0]      ntf_xlate,
  output logic [63:0]      ntf_mask,
  output logic [1:0]       ntf_perm
);

  localparam logic [63:0]      PMASK  = pg_mask(PAGE_SHIFT);
  localparam logic [63:0]      PSTEP  = 64'd1 << PAGE_SHIFT;
  localparam logic [CNT_W-1:0] ENT_C  = CNT_W'(ENTRIES);
  localparam logic [CNT_W-1:0] LIST_C = CNT_W'(MAX_LIST);

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_STEP, S_WAIT, S_APPLY, S_RSP
  } st_e;

  st_e              st_q;
  op_e              op_q;
  logic [63:0]      id_q, addr_q, arg_q, val_q, data_q;
  logic [CNT_W-1:0] cnt_q, iter_q;
  logic [1:0]       sts_q;

  // Checks made once, before any page is touched
  logic id_bad, fill_bad, list_bad, pre_bad;
  assign id_bad   = (id_q[63:32] != 32'd0) || (id_q[31:0] != TABLE_ID);
  assign fill_bad = (op_q == OP_FILL) && (cnt_q == '0 || cnt_q > ENT_C);
  assign list_bad = (op_q == OP_LIST) &&
                    (cnt_q == '0 || cnt_q > LIST_C ||
                     arg_q[LIST_ALIGN-1:0] != '0);
  assign pre_bad  = id_bad || fill_bad || list_bad;

  // Per-page index check
  logic [63:0] idx_full;
  logic        hit, last;
  assign idx_full = tbl_index(addr_q, BUS_OFFSET, PAGE_SHIFT);
  assign hit      = idx_full < 64'(ENTRIES);
  assign last     = (op_q == OP_PUT) || (iter_q + 1'b1 == cnt_q);

  logic do_write;
  assign do_write = (st_q == S_APPLY) && hit && (op_q != OP_GET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      op_q   <= OP_PUT;
      id_q   <= '0;
      addr_q <= '0;
      arg_q  <= '0;
      val_q  <= '0;
      data_q <= '0;
      cnt_q  <= '0;
      iter_q <= '0;
      sts_q  <= STS_OK;
    end else begin
      unique case (st_q)
        S_IDLE: if (cmd_valid) begin
          op_q   <= cmd_op;
          id_q   <= cmd_id;
          addr_q <= cmd_addr & PMASK;
          arg_q  <= cmd_arg;
          cnt_q  <= cmd_count;
          iter_q <= '0;
          data_q <= '0;
          st_q   <= S_CHECK;
        end
        S_CHECK: begin
          if (pre_bad) begin
            sts_q <= STS_PARM;
            st_q  <= S_RSP;
          end else begin
            st_q  <= S_STEP;
          end
        end
        S_STEP: begin
          if (op_q == OP_LIST) begin
            st_q <= S_WAIT;
          end else begin
            val_q <= arg_q;
            st_q  <= S_APPLY;
          end
        end
        S_WAIT: if (fetch_done) begin
          val_q <= fetch_value;
          st_q  <= S_APPLY;
        end
        S_APPLY: begin
          if (!hit) begin
            sts_q <= STS_PARM;
            st_q  <= S_RSP;
          end else if (op_q == OP_GET) begin
            data_q <= tbl_rdata;
            sts_q  <= STS_OK;
            st_q   <= S_RSP;
          end else if (last) begin
            sts_q <= STS_OK;
            st_q  <= S_RSP;
          end else begin
            iter_q <= iter_q + 1'b1;
            addr_q <= addr_q + PSTEP;
            st_q   <= S_STEP;
          end
        end
        S_RSP: if (rsp_ready) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready   = (st_q == S_IDLE);
  assign rsp_valid   = (st_q == S_RSP);
  assign rsp_status  = sts_q;
  assign rsp_data    = (sts_q == STS_OK) ? data_q : 64'd0;

  assign fetch_start = (st_q == S_STEP) && (op_q == OP_LIST);
  assign fetch_addr  = arg_q + (64'(iter_q) << 3);

  assign tbl_we      = do_write;
  assign tbl_idx     = idx_full[IDX_W-1:0];
  assign tbl_wdata   = val_q;

  assign ntf_valid   = do_write;
  assign ntf_iova    = (addr_q - BUS_OFFSET) & PMASK;
  assign ntf_xlate   = val_q & PMASK;
  assign ntf_mask    = ~PMASK;
  assign ntf_perm    = perm_of(val_q);

endmodule

// File: rtl/xlt_update_engine.sv
module xlt_update_engine
  import xlt_pkg::*;
#(
  parameter int          ENTRIES    = 64,
  parameter int          PAGE_SHIFT = 12,
  parameter logic [63:0] BUS_OFFSET = 64'h0010_0000,
  parameter logic [31:0] TABLE_ID   = 32'h8000_0001,
  parameter int          MAX_LIST   = 512,
  parameter int          LIST_ALIGN = 12,
  parameter int          CNT_W      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [63:0]      cmd_id,
  input  logic [63:0]      cmd_addr,
  input  logic [63:0]      cmd_arg,
  input  logic [CNT_W-1:0] cmd_count,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [1:0]       rsp_status,
  output logic [63:0]      rsp_data,
  output logic             mem_req,
  output logic [63:0]      mem_addr,
  input  logic             mem_ack,
  input  logic [63:0]      mem_rdata,
  output logic             ntf_valid,
  output logic [63:0]      ntf_iova,
  output logic [63:0]      ntf_xlate,
  output logic [63:0]      ntf_mask,
  output logic [1:0]       ntf_perm
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // Internal events, named for the checker
  logic             fetch_start, fetch_done, tbl_we;
  logic [63:0]      fetch_addr, fetch_value, tbl_wdata, tbl_rdata;
  logic [IDX_W-1:0] tbl_idx;

  xlt_seq #(
    .ENTRIES(ENTRIES), .PAGE_SHIFT(PAGE_SHIFT), .BUS_OFFSET(BUS_OFFSET),
    .TABLE_ID(TABLE_ID), .MAX_LIST(MAX_LIST), .LIST_ALIGN(LIST_ALIGN),
    .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_seq (
    .clk, .rst_n, .cmd_valid, .cmd_ready,
    .cmd_op(op_e'(cmd_op)), .cmd_id, .cmd_addr, .cmd_arg, .cmd_count,
    .rsp_valid, .rsp_ready, .rsp_status, .rsp_data,
    .fetch_start, .fetch_addr, .fetch_done, .fetch_value,
    .tbl_we, .tbl_idx, .tbl_wdata, .tbl_rdata,
    .ntf_valid, .ntf_iova, .ntf_xlate, .ntf_mask, .ntf_perm
  );

  xlt_fetch u_fetch (
    .clk, .rst_n, .start(fetch_start), .addr(fetch_addr),
    .mem_req, .mem_addr, .mem_ack, .mem_rdata,
    .done(fetch_done), .value(fetch_value)
  );

  xlt_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_tbl (
    .clk, .rst_n, .we(tbl_we), .waddr(tbl_idx), .wdata(tbl_wdata),
    .raddr(tbl_idx), .rdata(tbl_rdata)
  );

endmodule

// File: rtl/xlt_update_engine_chk.sv
module xlt_update_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [1:0]  rsp_status,
  input logic [63:0] rsp_data,
  input logic        mem_req,
  input logic [63:0] mem_addr,
  input logic        mem_ack,
  input logic        ntf_valid,
  input logic [63:0] ntf_iova,
  input logic [63:0] ntf_xlate,
  input logic [63:0] ntf_mask,
  input logic        fetch_done
);

  a_r10_busy_while_responding: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);

  a_r10_response_held: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_status) && $stable(rsp_data));

  a_r4_no_data_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status != 2'd0 |-> rsp_data == 64'd0);

  a_r9_notify_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> ((ntf_iova & ntf_mask) == 64'd0) && ((ntf_xlate & ntf_mask) == 64'd0));

  a_r7_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  a_r7_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[2:0] == 3'd0);

  a_r7_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> fetch_done && !mem_req);

  a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !ntf_valid && !mem_req);

endmodule

bind xlt_update_engine xlt_update_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_status(rsp_status), .rsp_data(rsp_data),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .ntf_valid(ntf_valid), .ntf_iova(ntf_iova), .ntf_xlate(ntf_xlate),
  .ntf_mask(ntf_mask), .fetch_done(fetch_done)
);

// File: tb/xlt_update_engine_bench.sv
module xlt_update_engine_bench;

  localparam logic [63:0] TID   = 64'h0000_0000_8000_0001;
  localparam logic [63:0] LBASE = 64'h0000_0000_0002_0000;

  typedef struct packed {
    logic [1:0]  op;
    logic [63:0] id;
    logic [63:0] addr;
    logic [63:0] arg;
    logic [1:0]  sts;
    logic [63:0] data;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'd0, TID,                   64'h10_0000, 64'hAAAA_0003,          2'd0, 64'd0},
    '{2'd1, TID,                   64'h10_0000, 64'd0,                  2'd0, 64'hAAAA_0003},
    '{2'd0, TID,                   64'h10_5ABC, 64'h1234_5001,          2'd0, 64'd0},
    '{2'd1, TID,                   64'h10_5000, 64'd0,                  2'd0, 64'h1234_5001},
    '{2'd0, TID,                   64'h14_0000, 64'h55,                 2'd1, 64'd0},
    '{2'd1, TID,                   64'h0F_F000, 64'd0,                  2'd1, 64'd0},
    '{2'd0, 64'h1_8000_0001,       64'h10_6000, 64'h77,                 2'd1, 64'd0},
    '{2'd0, 64'h8000_0002,         64'h10_6000, 64'h77,                 2'd1, 64'd0},
    '{2'd1, TID,                   64'h10_6000, 64'd0,                  2'd0, 64'd0},
    '{2'd1, TID,                   64'h13_F000, 64'd0,                  2'd0, 64'd0},
    '{2'd0, TID,                   64'h13_F123, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 64'd0},
    '{2'd1, TID,                   64'h13_F000, 64'd0,                  2'd0, 64'hFFFF_FFFF_FFFF_FFFF}
  };
  localparam string VREQ [NV] = '{"R1", "R4", "R1", "R1", "R2", "R2",
                                  "R3", "R3", "R3", "R2", "R1", "R4"};

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic [1:0]  cmd_op = '0;
  logic [63:0] cmd_id = '0, cmd_addr = '0, cmd_arg = '0;
  logic [31:0] cmd_count = '0;
  logic        rsp_valid, rsp_ready = 1'b0;
  logic [1:0]  rsp_status;
  logic [63:0] rsp_data;
  logic        mem_req, mem_ack = 1'b0;
  logic [63:0] mem_addr, mem_rdata = '0;
  logic        ntf_valid;
  logic [63:0] ntf_iova, ntf_xlate, ntf_mask;
  logic [1:0]  ntf_perm;

  always #5 clk = ~clk;

  xlt_update_engine u_xlt_update_engine (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_op, .cmd_id, .cmd_addr,
    .cmd_arg, .cmd_count, .rsp_valid, .rsp_ready, .rsp_status, .rsp_data,
    .mem_req, .mem_addr, .mem_ack, .mem_rdata,
    .ntf_valid, .ntf_iova, .ntf_xlate, .ntf_mask, .ntf_perm
  );

  int n_vec = 0, n_bad = 0, cyc = 0;

  // Memory model: list of 16 entries at LBASE, answered one cycle later
  logic [63:0] lst [16];
  int          mem_reads = 0;

  function automatic logic [63:0] to_bus(input logic [63:0] v);
    logic [63:0] r = '0;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = v[63-8*k -: 8];
    return r;
  endfunction

  always @(posedge clk) begin
    mem_ack <= mem_req && !mem_ack;
    if (mem_req && !mem_ack) begin
      mem_rdata <= to_bus(lst[4'((mem_addr - LBASE) >> 3)]);
      mem_reads <= mem_reads + 1;
    end
  end

  // Notification monitor
  int          n_ntf = 0;
  logic [63:0] l_iova, l_xlate, l_mask;
  logic [1:0]  l_perm;
  always @(negedge clk) begin
    if (rst_n && ntf_valid) begin
      n_ntf   <= n_ntf + 1;
      l_iova  <= ntf_iova;
      l_xlate <= ntf_xlate;
      l_mask  <= ntf_mask;
      l_perm  <= ntf_perm;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [1:0]  r_sts;
  logic [63:0] r_data;

  task automatic issue(input logic [1:0] op, input logic [63:0] id,
                       input logic [63:0] addr, input logic [63:0] arg,
                       input logic [31:0] cnt, input int hold);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_id = id;
    cmd_addr = addr; cmd_arg = arg; cmd_count = cnt;
    @(posedge clk);
    while (!cmd_ready) @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    for (int h = 0; h < hold; h++) @(negedge clk);
    r_sts  = rsp_status;
    r_data = rsp_data;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic read_back(input string req, input logic [63:0] addr, input logic [63:0] exp);
    issue(2'd1, TID, addr, 64'd0, 32'd0, 0);
    check(req, {62'd0, r_sts}, 64'd0);
    check(req, r_data, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int nb, mb;
    lst[0] = 64'h0102_0304_0506_0703;
    lst[1] = 64'hA1B2_C3D4_E5F6_0001;
    lst[2] = 64'h0000_00FF_EE00_1002;
    for (int i = 3; i < 16; i++) lst[i] = 64'h1000 * i + 64'h3;

    do_reset();
    // R11: reset state
    check("R11", {63'd0, cmd_ready}, 64'd1);
    check("R11", {63'd0, rsp_valid}, 64'd0);
    check("R11", {62'd0, mem_req, ntf_valid}, 64'd0);

    // Vector table: single writes and reads
    for (int v = 0; v < NV; v++) begin
      issue(VEC[v].op, VEC[v].id, VEC[v].addr, VEC[v].arg, 32'd1, 0);
      check(VREQ[v], {62'd0, r_sts}, {62'd0, VEC[v].sts});
      check(VREQ[v], r_data, VEC[v].data);
    end

    // R9: notification fields of a single write
    nb = n_ntf;
    issue(2'd0, TID, 64'h10_7FFF, 64'h00AB_CDE2, 32'd1, 0);
    check("R9", 64'(n_ntf - nb), 64'd1);
    check("R9", l_iova, 64'h7000);
    check("R9", l_xlate, 64'h00AB_C000);
    check("R9", l_mask, 64'hFFF);
    check("R9", {62'd0, l_perm}, 64'd2);

    // R5: fill three pages
    nb = n_ntf;
    issue(2'd2, TID, 64'h10_8000, 64'h5550_0003, 32'd3, 0);
    check("R5", {62'd0, r_sts}, 64'd0);
    check("R5", 64'(n_ntf - nb), 64'd3);
    read_back("R5", 64'h10_8000, 64'h5550_0003);
    read_back("R5", 64'h10_A000, 64'h5550_0003);
    read_back("R5", 64'h10_B000, 64'd0);

    // R5: rejected counts, no writes
    nb = n_ntf;
    issue(2'd2, TID, 64'h10_2000, 64'h9, 32'd65, 0);
    check("R5", {62'd0, r_sts}, 64'd1);
    issue(2'd2, TID, 64'h10_2000, 64'h9, 32'd0, 0);
    check("R5", {62'd0, r_sts}, 64'd1);
    check("R5", 64'(n_ntf - nb), 64'd0);
    read_back("R5", 64'h10_2000, 64'd0);

    // R8: fill runs off the end
    nb = n_ntf;
    issue(2'd2, TID, 64'h13_E000, 64'h9990_0001, 32'd4, 0);
    check("R8", {62'd0, r_sts}, 64'd1);
    check("R8", 64'(n_ntf - nb), 64'd2);
    read_back("R8", 64'h13_F000, 64'h9990_0001);

    // R7: list write of three big-endian entries
    mb = mem_reads;
    issue(2'd3, TID, 64'h10_C000, LBASE, 32'd3, 0);
    check("R7", {62'd0, r_sts}, 64'd0);
    check("R7", 64'(mem_reads - mb), 64'd3);
    read_back("R7", 64'h10_C000, lst[0]);
    read_back("R7", 64'h10_D000, lst[1]);
    read_back("R7", 64'h10_E000, lst[2]);

    // R6: rejected list commands touch no memory
    mb = mem_reads;
    issue(2'd3, TID, 64'h10_0000, LBASE, 32'd513, 0);
    check("R6", {62'd0, r_sts}, 64'd1);
    issue(2'd3, TID, 64'h10_0000, LBASE + 64'h8, 32'd1, 0);
    check("R6", {62'd0, r_sts}, 64'd1);
    issue(2'd3, TID, 64'h10_0000, LBASE, 32'd0, 0);
    check("R6", {62'd0, r_sts}, 64'd1);
    check("R6", 64'(mem_reads - mb), 64'd0);
    read_back("R6", 64'h10_0000, 64'hAAAA_0003);

    // R6 and R8: count 512 accepted, aborts at the second page
    mb = mem_reads;
    issue(2'd3, TID, 64'h13_F000, LBASE, 32'd512, 0);
    check("R8", {62'd0, r_sts}, 64'd1);
    check("R6", 64'(mem_reads - mb), 64'd2);
    read_back("R8", 64'h13_F000, lst[0]);

    // R10: response held while rsp_ready stays low
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd1; cmd_id = TID;
    cmd_addr = 64'h10_5000; cmd_count = 32'd0;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R10", {62'd0, rsp_valid, cmd_ready}, 64'd2);
    check("R10", rsp_data, 64'h1234_5001);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R10", {63'd0, cmd_ready}, 64'd1);

    // R11: second reset clears the table
    do_reset();
    read_back("R11", 64'h10_0000, 64'd0);
    read_back("R11", 64'h13_F000, 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule